// File: doc/BRIEF.md
# Indirect Read Transfer Engine

This block moves a software-sized run of bytes from a flash-like word source into a small on-chip buffer, from which a host collects it through a read window. Software programs a flash start address and a byte count, then writes the start bit of the control register. While the transfer is active the engine requests 32-bit words from the source. It stops requesting whenever the buffer is full and resumes as soon as the host frees a slot.

The host watches the fill level, which is counted in words, and pops words one at a time through the window. The transfer finishes on the pop that removes the last word: at that point in-progress drops and a sticky done flag rises. A cancel ends the transfer at once, empties the buffer and leaves done untouched.

The register port has four selector values: 0 is control, 1 is byte count, 2 is start address and 3 is level. In the control register, bit 0 is start, bit 1 is cancel, bit 2 is in-progress (read-only) and bit 5 is done.

Top module: `indirect_rd_engine`

## Requirements
- R1: After reset, in-progress, done and the fill level read 0, and `src_ready` is low.
- R2: A start write (control bit 0 = 1, bit 1 = 0) while idle with a nonzero count sets in-progress on that clock edge. `src_addr` then equals the programmed start address and advances by 4 for each accepted word.
- R3: A transfer of N bytes accepts exactly ceil(N/4) words from the source. After the last word has been accepted, `src_ready` stays low.
- R4: Byte k of a word occupies bits 8k+7:8k, lowest byte first. If N is not a multiple of 4, the bytes at positions N mod 4 and above in the final word are zero.
- R5: `src_ready` is low while the level equals DEPTH. It returns high in the cycle after a pop frees a slot, provided words are still owed.
- R6: The level register (selector 3) reports the word count in bits 15:0 and reads 0 in bits 31:16. A push and a pop in the same cycle leave the level unchanged.
- R7: Done stays 0 until the pop that removes the last word. That pop clears in-progress and sets done.
- R8: Done holds until a control write with bit 5 set clears it. If done is set and cleared in the same cycle, the set wins.
- R9: A cancel (control bit 1) while in progress clears in-progress, empties the buffer and does not set done. A cancel while idle changes nothing.
- R10: A start write while in progress is ignored, and the transfer continues from where it was.
- R11: Writes to the count and address registers while in progress are ignored.
- R12: A start with a count of 0 sets done on that edge, requests no words and leaves in-progress at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector: 0 control, 1 count, 2 address, 3 level |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| src_valid | input | 1 | Source word valid |
| src_ready | output | 1 | Engine accepts a source word |
| src_addr | output | 32 | Flash byte address of the requested word |
| src_data | input | 32 | Source word |
| win_rd | input | 1 | Host pop strobe for the read window |
| win_data | output | 32 | Oldest buffered word |

## Verification
The source push and the host pop can land on the same clock edge, and the buffer level must then stay where it was. The bench provokes this with the buffer full: one pop opens a slot, and a second pop is issued in the very cycle in which the engine refills that slot. The level must read DEPTH-1 afterwards and the popped data must be the next word in order. A second collision is also tested: the final pop, which sets done, coincides with a software write that clears done. Done must remain set after that cycle.

// File: rtl/indirect_rd_engine.sv
module indirect_rd_engine #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        src_valid,
  output logic        src_ready,
  output logic [31:0] src_addr,
  input  logic [31:0] src_data,
  input  logic        win_rd,
  output logic [31:0] win_data
);

  logic [31:0] nbytes, saddr, faddr;
  logic [31:0] fetch_left, drain_left;
  logic        busy, done;
  logic [31:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   level;
  logic [31:0]   keep;

  wire ctl_wr   = reg_wr && reg_sel == 2'd0;
  wire go       = ctl_wr && reg_wdata[0] && !reg_wdata[1] && !busy;
  wire abort    = ctl_wr && reg_wdata[1] && busy;
  wire push     = src_valid && src_ready;
  wire pop      = win_rd && level != '0;
  wire last_pop = busy && pop && drain_left == 32'd1 && !abort;
  wire [31:0] nwords = {2'b00, nbytes[31:2]} + {31'd0, |nbytes[1:0]};

  assign src_ready = busy && fetch_left != '0 && level != (AW+1)'(DEPTH);
  assign src_addr  = faddr;
  assign win_data  = mem[rptr];

  always_comb begin
    keep = '1;
    if (fetch_left == 32'd1)
      case (nbytes[1:0])
        2'd1:    keep = 32'h0000_00FF;
        2'd2:    keep = 32'h0000_FFFF;
        2'd3:    keep = 32'h00FF_FFFF;
        default: keep = '1;
      endcase
  end

  always_comb
    case (reg_sel)
      2'd0:    reg_rdata = {26'd0, done, 2'd0, busy, 2'd0};
      2'd1:    reg_rdata = nbytes;
      2'd2:    reg_rdata = saddr;
      default: reg_rdata = {16'd0, {(15-AW){1'b0}}, level};
    endcase

  always_ff @(posedge clk)
    if (push) mem[wptr] <= src_data & keep;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      nbytes     <= '0;
      saddr      <= '0;
      faddr      <= '0;
      fetch_left <= '0;
      drain_left <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      wptr       <= '0;
      rptr       <= '0;
      level      <= '0;
    end else begin
      if (reg_wr && reg_sel == 2'd1 && !busy) nbytes <= reg_wdata;
      if (reg_wr && reg_sel == 2'd2 && !busy) saddr  <= reg_wdata;

      if (ctl_wr && reg_wdata[5]) done <= 1'b0;
      if (last_pop || (go && nbytes == '0)) done <= 1'b1;

      if (abort) begin
        busy       <= 1'b0;
        fetch_left <= '0;
        drain_left <= '0;
        wptr       <= '0;
        rptr       <= '0;
        level      <= '0;
      end else begin
        if (go && nbytes != '0) begin
          busy       <= 1'b1;
          faddr      <= saddr;
          fetch_left <= nwords;
          drain_left <= nwords;
        end
        if (push) begin
          wptr       <= wptr + 1'b1;
          faddr      <= faddr + 32'd4;
          fetch_left <= fetch_left - 1'b1;
        end
        if (pop) begin
          rptr       <= rptr + 1'b1;
          drain_left <= drain_left - 1'b1;
        end
        if (last_pop) busy <= 1'b0;
        case ({push, pop})
          2'b10:   level <= level + 1'b1;
          2'b01:   level <= level - 1'b1;
          default: level <= level;
        endcase
      end
    end

endmodule

module indirect_rd_engine_chk #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [AW:0] level,
  input logic        src_ready,
  input logic        reg_wr,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_wdata
);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));

  // R5
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level == (AW+1)'(DEPTH) |-> !src_ready);

  // R3
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> busy);

  // R9
  cancel_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && reg_wdata[1] && busy)
      |=> (!busy && level == '0 && !$rose(done)));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(reg_wr && reg_sel == 2'd0 && reg_wdata[5]));

endmodule

bind indirect_rd_engine indirect_rd_engine_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .level(level),
  .src_ready(src_ready), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata)
);

// File: tb/sim_indirect_rd_engine.sv
`timescale 1ns/1ps
module sim_indirect_rd_engine;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [31:0] src_addr;
  logic [31:0] src_data;
  logic        win_rd = 1'b0;
  logic [31:0] win_data;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] fn(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0F0F_1234;
  endfunction

  assign src_data = fn(src_addr);

  indirect_rd_engine #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_valid(src_valid),
    .src_ready(src_ready), .src_addr(src_addr), .src_data(src_data),
    .win_rd(win_rd), .win_data(win_data)
  );

  localparam logic [63:0] VEC [5] = '{
    {32'h0000_0100, 32'd16},
    {32'h0000_2000, 32'd5},
    {32'h0000_0040, 32'd7},
    {32'h0000_3000, 32'd1},
    {32'h0000_0080, 32'd40}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic pop(output logic [31:0] v);
    v = win_data; win_rd = 1'b1;
    @(negedge clk);
    win_rd = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, a, n, m;
    int words;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 control", v, 32'h0);
    rd(2'd3, v); check("R1 level", v, 32'h0);
    check("R1 src_ready", {31'd0, src_ready}, 32'h0);

    src_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      a = VEC[i][63:32];
      n = VEC[i][31:0];
      words = int'((n + 3) / 4);
      wr(2'd2, a);
      wr(2'd1, n);
      wr(2'd0, 32'h1);
      rd(2'd0, v); check("R2 busy after start", v & 32'h24, 32'h04);
      check("R2 first address", src_addr, a);
      for (int k = 0; k < words; k++) begin
        rd(2'd3, v);
        while (v[15:0] == 16'd0) begin
          @(negedge clk);
          rd(2'd3, v);
        end
        if (k == words - 1) begin
          rd(2'd0, v); check("R7 done before last pop", v & 32'h20, 32'h0);
        end
        m = 32'hFFFF_FFFF;
        if (k == words - 1 && n[1:0] != 2'd0) m = (32'h1 << (8 * n[1:0])) - 1;
        pop(v);
        check("R4 word data", v, fn(a + 32'(4 * k)) & m);
      end
      rd(2'd0, v); check("R7 done after last pop", v & 32'h24, 32'h20);
      check("R3 no request after count", {31'd0, src_ready}, 32'h0);
      check("R3 word count", src_addr, a + 32'(4 * words));
      wr(2'd0, 32'h20);
      rd(2'd0, v); check("R8 done cleared", v & 32'h20, 32'h0);
    end

    // R5 backpressure, R6 simultaneous push and pop
    wr(2'd2, 32'h4000);
    wr(2'd1, 32'd48);
    wr(2'd0, 32'h1);
    repeat (20) @(negedge clk);
    rd(2'd3, v); check("R5 level full", v, DEPTH);
    check("R5 stalled when full", {31'd0, src_ready}, 32'h0);
    check("R5 address at stall", src_addr, 32'h4020);
    pop(v); check("R5 pop data", v, fn(32'h4000));
    check("R5 resumes after pop", {31'd0, src_ready}, 32'h1);
    pop(v); check("R6 pop with push data", v, fn(32'h4004));
    rd(2'd3, v); check("R6 level unchanged", v, DEPTH - 1);
    src_valid = 1'b0;

    // R11 register writes while busy
    wr(2'd2, 32'hDEAD_0000);
    wr(2'd1, 32'd4);
    rd(2'd2, v); check("R11 address kept", v, 32'h4000);
    rd(2'd1, v); check("R11 count kept", v, 32'd48);

    // R10 start while busy
    wr(2'd0, 32'h1);
    check("R10 address continues", src_addr, 32'h4024);
    rd(2'd3, v); check("R10 level kept", v, DEPTH - 1);

    // R9 cancel in progress
    wr(2'd0, 32'h2);
    rd(2'd0, v); check("R9 cancel control", v, 32'h0);
    rd(2'd3, v); check("R9 buffer flushed", v, 32'h0);
    check("R9 no request", {31'd0, src_ready}, 32'h0);
    pop(v);
    rd(2'd3, v); check("R9 pop on empty", v, 32'h0);

    // R12 zero count
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h1);
    rd(2'd0, v); check("R12 zero count done", v, 32'h20);
    check("R12 no request", {31'd0, src_ready}, 32'h0);

    // R9 cancel while idle
    wr(2'd0, 32'h2);
    rd(2'd0, v); check("R9 idle cancel no effect", v, 32'h20);
    wr(2'd0, 32'h20);

    // R8 done set and clear in the same cycle
    wr(2'd2, 32'h0500);
    wr(2'd1, 32'd4);
    wr(2'd0, 32'h1);
    src_valid = 1'b1;
    repeat (3) @(negedge clk);
    win_rd = 1'b1;
    reg_sel = 2'd0; reg_wdata = 32'h20; reg_wr = 1'b1;
    @(negedge clk);
    win_rd = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v); check("R8 set wins over clear", v, 32'h20);

    finish_run();
  end
endmodule